// File: doc/BRIEF.md
# Shared Address/Data External Bus Controller

This block lets a core reach external static memory or simple peripherals over one set of bus lines that carry first an address and then data. Each access runs as three phases. In the address phase the block drives an address and raises the address-latch strobe, so an external latch can hold the address. In the strobe phase it raises the read or write strobe. In the release phase it drops the strobe and returns the result to the core.

Two device widths are supported. For a narrow device (half the bus width) the address phase carries the upper address bits. The lowest address byte then travels on the upper half of the bus during the data phase, next to the data on the lower half. This reaches a 24-bit address on a 16-line bus. For a wide device the address phase carries a 16-bit address and the data phase carries all 16 data lines.

The core side is a single-request handshake: address, write data, direction and width go in; read data and a one-clock completion pulse come out. The bus is given as separate out, in and per-half output-enable signals.

Top module: `ad_mux_port`

## Requirements
- R1: After reset the port is ready, and `rsp_done`, `ale`, `rd_stb`, `wr_stb`, both bits of `ad_oe` and `rsp_rdata` are all zero.
- R2: A request that arrives while `req_ready` is low is ignored. It starts no address phase and does not change the bus drive of the transfer in progress.
- R3: An accepted request produces, on the next three clocks in order, one address phase (`ale` high, no strobe), one strobe phase (exactly one of `rd_stb`/`wr_stb` high) and one release phase (no strobe, `rsp_done` high). `rsp_done` lasts exactly one clock per transfer.
- R4: Wide mode (`req_wide`=1), address phase: `ad_out` equals `req_addr[15:0]` with `ad_oe`=2'b11. Address bits 23:16 have no effect.
- R5: Narrow mode (`req_wide`=0), address phase: `ad_out` equals `req_addr[23:8]` with `ad_oe`=2'b11.
- R6: Wide write, strobe and release phases: `ad_out` equals the write data and `ad_oe`=2'b11.
- R7: Narrow write, strobe and release phases: `ad_out[15:8]` equals `req_addr[7:0]`, `ad_out[7:0]` equals `req_wdata[7:0]`, and `ad_oe`=2'b11.
- R8: Wide read: in the strobe phase `ad_oe`=2'b00. `rsp_rdata` equals `ad_in` as sampled on the clock edge that ends the strobe phase.
- R9: Narrow read: in the strobe phase `ad_oe`=2'b10 (bit 1 is the upper half) and `ad_out[15:8]` equals `req_addr[7:0]`. `rsp_rdata` is `{8'h00, ad_in[7:0]}` as sampled on the edge that ends the strobe phase.
- R10: `req_ready` is high in the release phase. A request presented there starts its address phase on the next clock, so back-to-back transfers take three clocks each.
- R11: `rsp_rdata` changes only on the edge that ends a read strobe phase. A change of `ad_in` after that edge does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data (low byte only in narrow mode) |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Last read data |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_in | input | 16 | Value seen on the shared lines |
| ad_oe | output | 2 | Drive enable per bus half, bit 1 upper |
| ale | output | 1 | Address latch strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |

## Verification
The bench walks a single one through every address bit in both widths and both directions. A design that mixed up the narrow and wide address slices, or that let bits 23:16 leak into a wide address, shows a wrong `ad_out` in the address phase. Read transfers change `ad_in` right after the capture edge, and the bench then checks `rsp_rdata` over the following idle cycle. A design that samples one clock late returns the changed value, and one that forgets to zero-extend in narrow mode returns a nonzero upper byte. Transfers run both back-to-back and with an idle gap, and one request is posted while the port is busy. A port that stalls after the release phase, or that accepts the busy request, places `ale` in the wrong cycle.

// File: rtl/ad_mux_pkg.sv
package ad_mux_pkg;

   // Transfer phases; the order is the bus sequence.
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_ADDR    = 2'd1,
      PH_STROBE  = 2'd2,
      PH_RELEASE = 2'd3
   } phase_e;

   // True in the phases that carry data on the bus.
   function automatic logic is_data_phase(input phase_e ph);
      return (ph == PH_STROBE) || (ph == PH_RELEASE);
   endfunction

endpackage

// File: rtl/ad_mux_seq.sv
module ad_mux_seq
   import ad_mux_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_e phase,
   output logic   ready,
   output logic   done
);

   phase_e phase_q;
   phase_e phase_d;

   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_IDLE:    if (start) phase_d = PH_ADDR;
         PH_ADDR:    phase_d = PH_STROBE;
         PH_STROBE:  phase_d = PH_RELEASE;
         PH_RELEASE: phase_d = start ? PH_ADDR : PH_IDLE;
         default:    phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase = phase_q;
   assign ready = (phase_q == PH_IDLE) || (phase_q == PH_RELEASE);
   assign done  = (phase_q == PH_RELEASE);

endmodule

// File: rtl/ad_mux_req_latch.sv
module ad_mux_req_latch #(
   parameter int ADDR_W = 24,
   parameter int BUS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              write,
   input  logic              wide,
   output logic [ADDR_W-1:0] q_addr,
   output logic [BUS_W-1:0]  q_wdata,
   output logic              q_write,
   output logic              q_wide
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_wdata <= '0;
         q_write <= 1'b0;
         q_wide  <= 1'b0;
      end else if (load) begin
         q_addr  <= addr;
         q_wdata <= wdata;
         q_write <= write;
         q_wide  <= wide;
      end
   end

endmodule

// File: rtl/ad_mux_drive.sv
module ad_mux_drive
   import ad_mux_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 24
) (
   input  phase_e            phase,
   input  logic [ADDR_W-1:0] q_addr,
   input  logic [BUS_W-1:0]  q_wdata,
   input  logic              q_write,
   input  logic              q_wide,
   output logic [BUS_W-1:0]  ad_out,
   output logic [1:0]        ad_oe,
   output logic              ale,
   output logic              rd_stb,
   output logic              wr_stb
);

   localparam int HALF_W = BUS_W / 2;

   // Each bus half picks its address and data sources separately.
   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF_W-1:0] addr_part;
      logic [HALF_W-1:0] data_part;
      logic              data_en;
      logic [HALF_W-1:0] out_h;
      logic              oe_h;

      // Wide: low address bits; narrow: the address above the first byte.
      assign addr_part = q_wide ? q_addr[h*HALF_W +: HALF_W]
                                : q_addr[HALF_W + h*HALF_W +: HALF_W];

      if (h == 1) begin : g_upper
         // Narrow devices take the low address byte on the upper half.
         assign data_part = q_wide ? q_wdata[HALF_W +: HALF_W]
                                   : q_addr[0 +: HALF_W];
         assign data_en   = q_wide ? q_write : 1'b1;
      end else begin : g_lower
         assign data_part = q_wdata[0 +: HALF_W];
         assign data_en   = q_write;
      end

      always_comb begin
         out_h = '0;
         oe_h  = 1'b0;
         if (phase == PH_ADDR) begin
            out_h = addr_part;
            oe_h  = 1'b1;
         end else if (is_data_phase(phase)) begin
            out_h = data_en ? data_part : '0;
            oe_h  = data_en;
         end
      end

      assign ad_out[h*HALF_W +: HALF_W] = out_h;
      assign ad_oe[h]                   = oe_h;
   end

   assign ale    = (phase == PH_ADDR);
   assign rd_stb = (phase == PH_STROBE) && !q_write;
   assign wr_stb = (phase == PH_STROBE) &&  q_write;

endmodule

// File: rtl/ad_mux_capture.sv
module ad_mux_capture #(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grab,
   input  logic             wide,
   input  logic [BUS_W-1:0] ad_in,
   output logic [BUS_W-1:0] rdata
);

   localparam int HALF_W = BUS_W / 2;

   logic [BUS_W-1:0] sample;

   assign sample = wide ? ad_in : {{HALF_W{1'b0}}, ad_in[HALF_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata <= '0;
      else if (grab) rdata <= sample;
   end

endmodule

// File: rtl/ad_mux_port.sv
module ad_mux_port
   import ad_mux_pkg::*;
#(
   parameter  int BUS_W  = 16,
   localparam int HALF_W = BUS_W / 2,
   localparam int ADDR_W = BUS_W + HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_wide,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BUS_W-1:0]  req_wdata,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [BUS_W-1:0]  rsp_rdata,
   output logic [BUS_W-1:0]  ad_out,
   input  logic [BUS_W-1:0]  ad_in,
   output logic [1:0]        ad_oe,
   output logic              ale,
   output logic              rd_stb,
   output logic              wr_stb
);

   if ((BUS_W % 2) != 0 || BUS_W < 4) begin : g_bad_width
      $error("ad_mux_port: BUS_W must be even and at least 4");
   end

   phase_e            phase;
   logic              start;
   logic [ADDR_W-1:0] q_addr;
   logic [BUS_W-1:0]  q_wdata;
   logic              q_write;
   logic              q_wide;
   logic              grab;

   assign start = req_valid && req_ready;

   ad_mux_seq seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .phase (phase),
      .ready (req_ready),
      .done  (rsp_done)
   );

   ad_mux_req_latch #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) latch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .write   (req_write),
      .wide    (req_wide),
      .q_addr  (q_addr),
      .q_wdata (q_wdata),
      .q_write (q_write),
      .q_wide  (q_wide)
   );

   ad_mux_drive #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) drive_i (
      .phase   (phase),
      .q_addr  (q_addr),
      .q_wdata (q_wdata),
      .q_write (q_write),
      .q_wide  (q_wide),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .ale     (ale),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb)
   );

   // Sample on the edge that closes the read strobe.
   assign grab = (phase == PH_STROBE) && !q_write;

   ad_mux_capture #(.BUS_W(BUS_W)) cap_i (
      .clk   (clk),
      .rst_n (rst_n),
      .grab  (grab),
      .wide  (q_wide),
      .ad_in (ad_in),
      .rdata (rsp_rdata)
   );

endmodule

// File: rtl/ad_mux_port_chk.sv
module ad_mux_port_chk #(
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_done,
   input logic [BUS_W-1:0] rsp_rdata,
   input logic [1:0]       ad_oe,
   input logic             ale,
   input logic             rd_stb,
   input logic             wr_stb
);

   AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (!rd_stb && !wr_stb)); // R3
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb)); // R3
   AST_ALE_TO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (rd_stb || wr_stb)); // R3
   AST_STROBE_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || wr_stb) |=> (rsp_done && !rd_stb && !wr_stb && !ale)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R3
   AST_BUSY_NO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || !req_ready) |=> !ale); // R2
   AST_ACCEPT_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> ale); // R10
   AST_ALE_FULL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe == 2'b11)); // R4
   AST_READ_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> !ad_oe[0]); // R8
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_rdata) |-> rsp_done); // R11

endmodule

bind ad_mux_port ad_mux_port_chk #(.BUS_W(BUS_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .rsp_rdata (rsp_rdata),
   .ad_oe     (ad_oe),
   .ale       (ale),
   .rd_stb    (rd_stb),
   .wr_stb    (wr_stb)
);

// File: tb/ad_mux_port_tb.sv
`timescale 1ns/1ps
module ad_mux_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_wide = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic [15:0] ad_out;
   logic [15:0] ad_in = '0;
   logic [1:0]  ad_oe;
   logic        ale;
   logic        rd_stb;
   logic        wr_stb;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [15:0] last_rd = '0;

   always #10 clk = ~clk;

   ad_mux_port dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale),
      .rd_stb(rd_stb), .wr_stb(wr_stb)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Starts at a negedge with the port ready; returns at the release-phase negedge.
   task automatic xfer(input bit wide, input bit wr, input logic [23:0] a,
                       input logic [15:0] d, input logic [15:0] rv, input bit poke);
      logic [15:0] exp_bus;
      req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = d;
      @(negedge clk);
      // address phase
      req_valid = 1'b0;
      chk("R3 ale in address phase", {ale, rd_stb, wr_stb}, 3'b100);
      chk("R4/R5 address phase oe", ad_oe, 2'b11);
      chk(wide ? "R4 wide address" : "R5 narrow address", ad_out,
          wide ? a[15:0] : a[23:8]);
      chk("R2 busy in address phase", req_ready, 1'b0);
      @(negedge clk);
      // strobe phase
      chk("R3 strobe phase", {ale, rd_stb, wr_stb}, {1'b0, !wr, wr});
      if (wr) begin
         exp_bus = wide ? d : {a[7:0], d[7:0]};
         chk(wide ? "R6 wide write oe" : "R7 narrow write oe", ad_oe, 2'b11);
         chk(wide ? "R6 wide write data" : "R7 narrow write data", ad_out, exp_bus);
      end else begin
         exp_bus = {a[7:0], 8'h00};
         if (wide) chk("R8 wide read oe off", ad_oe, 2'b00);
         else begin
            chk("R9 narrow read oe", ad_oe, 2'b10);
            chk("R9 narrow read address byte", ad_out[15:8], a[7:0]);
         end
         ad_in = rv;
      end
      if (poke) begin
         req_valid = 1'b1; req_addr = 24'hFFFFFF; req_wide = !wide; req_wdata = ~d;
      end
      @(negedge clk);
      // release phase
      if (poke) begin
         req_valid = 1'b0;
         chk("R2 busy request leaves data drive", ad_out, exp_bus);
      end
      chk("R3 release phase", {ale, rd_stb, wr_stb, rsp_done}, 4'b0001);
      chk("R10 ready in release", req_ready, 1'b1);
      if (wr) chk(wide ? "R6 write held in release" : "R7 write held in release",
                  ad_out, exp_bus);
      else begin
         last_rd = wide ? rv : {8'h00, rv[7:0]};
         chk(wide ? "R8 wide read data" : "R9 narrow read data", rsp_rdata, last_rd);
         ad_in = ~rv;
      end
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      chk("R3 done one clock", rsp_done, 1'b0);
      chk("R2 no ale without request", ale, 1'b0);
      chk("R11 read data held", rsp_rdata, last_rd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", req_ready, 1'b1);
      chk("R1 strobes after reset", {rsp_done, ale, rd_stb, wr_stb}, 4'b0000);
      chk("R1 oe after reset", ad_oe, 2'b00);
      chk("R1 rdata after reset", rsp_rdata, 16'h0000);

      for (int m = 0; m < 2; m++) begin
         for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < 24; i++) begin
               logic [23:0] a;
               logic [15:0] d;
               logic [15:0] rv;
               a  = 24'h1 << i;
               d  = (16'h1 << (i % 16)) ^ 16'h5A3C;
               rv = 16'(i * 16'h1357) ^ 16'hA5A5;
               xfer(m[0], w[0], a, d, rv, 1'b0);
               // odd steps chain straight into the next request (R10)
               if ((i % 2) == 0) idle_cycle();
            end
            idle_cycle();
         end
      end

      // R2: request posted while busy must be ignored
      xfer(1'b1, 1'b1, 24'h001234, 16'hBEEF, 16'h0000, 1'b1);
      idle_cycle();
      xfer(1'b0, 1'b0, 24'hABCDEF, 16'h0000, 16'h77C3, 1'b1);
      idle_cycle();

      finish_run();
   end

endmodule